// File: doc/BRIEF.md
# Display window update sequencer

This block refreshes a rectangular region of an attached display panel. On an accepted request it produces, as a byte stream, the command that sets the column window, the command that sets the row window and the command that opens a memory write. It then streams the region's pixels as 16-bit RGB565 data. The stream carries a command/data flag and a valid/ready handshake, so any serial display link can sit below it.

The rectangle is given as a start corner and an exclusive end corner. Pixels come from a valid/ready source port in raster order. The source may deliver native RGB565 words or 32-bit XRGB words. XRGB words are packed to RGB565 as they pass. An optional byte swap reverses the two bytes of every pixel. When the block is disabled, requests are taken and thrown away. A request that arrives while a refresh is running is ignored.

Top module: `win_refresh_seq`

## Requirements
- R1: A refresh starts with command byte 0x2A, then four parameter bytes, then command byte 0x2B, then four parameter bytes, then command byte 0x2C. Command bytes carry out_is_data=0. Parameter and pixel bytes carry out_is_data=1.
- R2: Each window command's four parameters are sent in this order: start high byte, start low byte, end high byte, end low byte. The 0x2A parameters use the x coordinates and the 0x2B parameters use the y coordinates. The end value sent is the exclusive end minus one.
- R3: After 0x2C exactly (x1-x0)*(y1-y0)*2 data bytes follow. Pixels are taken from the source one per pix_valid/pix_ready handshake, in row-major order from top to bottom and left to right.
- R4: With fmt_xrgb=0, the pixel value is pix_data[15:0].
- R5: With fmt_xrgb=1, the pixel value is {pix_data[23:19], pix_data[15:10], pix_data[7:3]}.
- R6: With swap_bytes=0, each pixel is sent high byte first. With swap_bytes=1, the low byte is sent first. Format and swap are sampled when the request is accepted.
- R7: A request with enable=0 produces no output byte, no pixel fetch, no busy and no done.
- R8: A request that arrives while busy=1 has no effect on the stream in progress or on what follows it.
- R9: done is a single-cycle pulse. It is high in the cycle after the last pixel byte's handshake, and in that same cycle busy has returned to 0.
- R10: While out_valid=1 and out_ready=0, out_valid stays high and out_data stays unchanged, except while waiting for the first byte of a pixel from the source.
- R11: After reset, out_valid, pix_ready, busy and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Refresh requests are acted on only when high |
| fmt_xrgb | input | 1 | 1: source words are XRGB, 0: source words are RGB565 |
| swap_bytes | input | 1 | 1: send the low byte of each pixel first |
| req_valid | input | 1 | Refresh request strobe |
| req_x0 | input | COORD_W | Start column, inclusive |
| req_y0 | input | COORD_W | Start row, inclusive |
| req_x1 | input | COORD_W | End column, exclusive |
| req_y1 | input | COORD_W | End row, exclusive |
| pix_valid | input | 1 | Source pixel available |
| pix_data | input | PIX_W | Source pixel word |
| pix_ready | output | 1 | Source pixel taken this cycle |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte |
| out_is_data | output | 1 | 1: parameter or pixel byte, 0: command byte |
| out_ready | input | 1 | Downstream accepts the byte |
| busy | output | 1 | A refresh is in progress |
| done | output | 1 | One-cycle pulse when a refresh completes |

## Verification
The hardest situation to reach is a second request that lands in the middle of a running refresh while the downstream is stalling. The bench starts a refresh, lets the output stall under a pseudo-random ready pattern, and then pulses a request with other coordinates. The scoreboard then has to see the first refresh's bytes unchanged, followed by silence. Coordinate pairs whose end value crosses a byte boundary (0x01FF to 0x0200) exercise the high-byte parameters and the minus-one on the end coordinate.

// File: rtl/wr_pkg.sv
package wr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_PIX_A,
        ST_PIX_B
    } wr_state_e;

    localparam logic [7:0] OP_COL_WIN = 8'h2A;
    localparam logic [7:0] OP_ROW_WIN = 8'h2B;
    localparam logic [7:0] OP_MEM_WR  = 8'h2C;
    localparam int unsigned HDR_LEN   = 11;
endpackage

// File: rtl/wr_px_pack.sv
module wr_px_pack #(
    parameter int unsigned PIX_W = 32
) (
    input  logic [PIX_W-1:0] pix,
    input  logic             fmt_xrgb,
    input  logic             swap,
    output logic [7:0]       first_byte,
    output logic [7:0]       second_byte
);
    logic [15:0] rgb565;

    always_comb begin
        if (fmt_xrgb) rgb565 = {pix[23:19], pix[15:10], pix[7:3]};
        else          rgb565 = pix[15:0];
        first_byte  = swap ? rgb565[7:0]  : rgb565[15:8];
        second_byte = swap ? rgb565[15:8] : rgb565[7:0];
    end
endmodule

// File: rtl/wr_win_hdr.sv
module wr_win_hdr #(
    parameter int unsigned COORD_W = 16
) (
    input  logic [3:0]         idx,
    input  logic [COORD_W-1:0] xs,
    input  logic [COORD_W-1:0] xe,
    input  logic [COORD_W-1:0] ys,
    input  logic [COORD_W-1:0] ye,
    output logic [7:0]         hdr_byte,
    output logic               hdr_is_data
);
    import wr_pkg::*;

    logic [15:0] xs16, xe16, ys16, ye16;

    always_comb begin
        xs16 = 16'(xs);
        xe16 = 16'(xe);
        ys16 = 16'(ys);
        ye16 = 16'(ye);
        hdr_is_data = 1'b1;
        case (idx)
            4'd0:    begin hdr_byte = OP_COL_WIN; hdr_is_data = 1'b0; end
            4'd1:    hdr_byte = xs16[15:8];
            4'd2:    hdr_byte = xs16[7:0];
            4'd3:    hdr_byte = xe16[15:8];
            4'd4:    hdr_byte = xe16[7:0];
            4'd5:    begin hdr_byte = OP_ROW_WIN; hdr_is_data = 1'b0; end
            4'd6:    hdr_byte = ys16[15:8];
            4'd7:    hdr_byte = ys16[7:0];
            4'd8:    hdr_byte = ye16[15:8];
            4'd9:    hdr_byte = ye16[7:0];
            default: begin hdr_byte = OP_MEM_WR; hdr_is_data = 1'b0; end
        endcase
    end
endmodule

// File: rtl/win_refresh_seq.sv
module win_refresh_seq
    import wr_pkg::*;
#(
    parameter int unsigned COORD_W = 16,
    parameter int unsigned PIX_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               fmt_xrgb,
    input  logic               swap_bytes,
    input  logic               req_valid,
    input  logic [COORD_W-1:0] req_x0,
    input  logic [COORD_W-1:0] req_y0,
    input  logic [COORD_W-1:0] req_x1,
    input  logic [COORD_W-1:0] req_y1,
    input  logic               pix_valid,
    input  logic [PIX_W-1:0]   pix_data,
    output logic               pix_ready,
    output logic               out_valid,
    output logic [7:0]         out_data,
    output logic               out_is_data,
    input  logic               out_ready,
    output logic               busy,
    output logic               done
);
    localparam logic [COORD_W-1:0] ONE      = COORD_W'(1);
    localparam logic [3:0]         HDR_LAST = 4'(HDR_LEN - 1);

    typedef struct packed {
        wr_state_e          state;
        logic [3:0]         hdr_idx;
        logic [COORD_W-1:0] xs;
        logic [COORD_W-1:0] xe;
        logic [COORD_W-1:0] ys;
        logic [COORD_W-1:0] ye;
        logic [COORD_W-1:0] col;
        logic [COORD_W-1:0] row;
        logic [COORD_W-1:0] wlast;
        logic [COORD_W-1:0] hlast;
        logic               fmt;
        logic               swap;
        logic [7:0]         lo_byte;
        logic               done;
    } wr_regs_t;

    wr_regs_t r_q, r_d;

    logic [7:0] hdr_byte, px_first, px_second;
    logic       hdr_is_data;

    wr_win_hdr #(.COORD_W(COORD_W)) u_hdr (
        .idx         (r_q.hdr_idx),
        .xs          (r_q.xs),
        .xe          (r_q.xe),
        .ys          (r_q.ys),
        .ye          (r_q.ye),
        .hdr_byte    (hdr_byte),
        .hdr_is_data (hdr_is_data)
    );

    wr_px_pack #(.PIX_W(PIX_W)) u_pack (
        .pix         (pix_data),
        .fmt_xrgb    (r_q.fmt),
        .swap        (r_q.swap),
        .first_byte  (px_first),
        .second_byte (px_second)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        out_valid   = 1'b0;
        out_data    = 8'h00;
        out_is_data = 1'b1;
        pix_ready   = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid && enable) begin
                    r_d.state   = ST_HDR;
                    r_d.hdr_idx = 4'd0;
                    r_d.xs      = req_x0;
                    r_d.ys      = req_y0;
                    r_d.xe      = req_x1 - ONE;
                    r_d.ye      = req_y1 - ONE;
                    r_d.wlast   = req_x1 - req_x0 - ONE;
                    r_d.hlast   = req_y1 - req_y0 - ONE;
                    r_d.col     = '0;
                    r_d.row     = '0;
                    r_d.fmt     = fmt_xrgb;
                    r_d.swap    = swap_bytes;
                end
            end
            ST_HDR: begin
                out_valid   = 1'b1;
                out_data    = hdr_byte;
                out_is_data = hdr_is_data;
                if (out_ready) begin
                    if (r_q.hdr_idx == HDR_LAST) r_d.state = ST_PIX_A;
                    else r_d.hdr_idx = r_q.hdr_idx + 4'd1;
                end
            end
            ST_PIX_A: begin
                out_valid = pix_valid;
                out_data  = px_first;
                pix_ready = out_ready;
                if (pix_valid && out_ready) begin
                    r_d.lo_byte = px_second;
                    r_d.state   = ST_PIX_B;
                end
            end
            default: begin
                out_valid = 1'b1;
                out_data  = r_q.lo_byte;
                if (out_ready) begin
                    r_d.state = ST_PIX_A;
                    if (r_q.col == r_q.wlast) begin
                        r_d.col = '0;
                        if (r_q.row == r_q.hlast) begin
                            r_d.state = ST_IDLE;
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.row = r_q.row + ONE;
                        end
                    end else begin
                        r_d.col = r_q.col + ONE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.state != ST_IDLE);
    assign done = r_q.done;

    // R1: a byte flagged as a command is always one of the three opcodes
    p_cmd_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_data) |->
        (out_data == OP_COL_WIN || out_data == OP_ROW_WIN || out_data == OP_MEM_WR));

    // R10: a stalled byte is held
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && r_q.state != ST_PIX_A) |=>
        (out_valid && $stable(out_data)));

    // R9: done follows a data byte handshake and lasts one cycle
    p_done_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid && out_ready && out_is_data) && !busy));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a disabled idle block stays idle
    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !enable) |=> !busy);

    // R3: pixels are fetched only while a refresh streams data
    p_pix_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> (busy && out_is_data));
endmodule

// File: tb/win_refresh_seq_tb.sv
module win_refresh_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int PW = 32;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, fmt_xrgb = 1'b0, swap_bytes = 1'b0, req_valid = 1'b0;
    logic [CW-1:0] req_x0 = '0, req_y0 = '0, req_x1 = '0, req_y1 = '0;
    logic pix_ready, out_valid, out_is_data, busy, done;
    logic [7:0] out_data;
    logic out_ready = 1'b1;
    logic [PW-1:0] pix_data;
    int unsigned pix_idx = 0;
    int unsigned exp_base = 0;
    int cyc = 0;
    int last_hs = 0;
    int checks = 0, errors = 0;
    bit rnd_ready = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [10:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [PW-1:0] pixf(int unsigned k);
        return 32'h5A3C_96E1 ^ (k * 32'h0101_0F13);
    endfunction

    assign pix_data = pixf(pix_idx);

    win_refresh_seq #(.COORD_W(CW), .PIX_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fmt_xrgb(fmt_xrgb),
        .swap_bytes(swap_bytes), .req_valid(req_valid),
        .req_x0(req_x0), .req_y0(req_y0), .req_x1(req_x1), .req_y1(req_y1),
        .pix_valid(1'b1), .pix_data(pix_data), .pix_ready(pix_ready),
        .out_valid(out_valid), .out_data(out_data), .out_is_data(out_is_data),
        .out_ready(out_ready), .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && pix_ready) pix_idx <= pix_idx + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: kind 0 = command (R1), 1 = window parameter (R2), 2 = pixel (R4/R5/R6)
    always begin
        @(negedge clk);
        out_ready = rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        #1;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7/R8 unexpected byte", {out_is_data, out_data}, 0);
            end else begin
                logic [10:0] e;
                e = exp_q[0];
                case (e[10:9])
                    2'd0:    chk({out_is_data, out_data} == e[8:0], "R1 command", {out_is_data, out_data}, e[8:0]);
                    2'd1:    chk({out_is_data, out_data} == e[8:0], "R2 parameter", {out_is_data, out_data}, e[8:0]);
                    default: chk({out_is_data, out_data} == e[8:0], "R4/R5/R6/R10 pixel byte", {out_is_data, out_data}, e[8:0]);
                endcase
                if (out_ready) begin
                    void'(exp_q.pop_front());
                    last_hs = cyc + 1;
                end
            end
        end
    end

    task automatic push_exp(input logic [1:0] kind, input bit isd, input logic [7:0] b);
        exp_q.push_back({kind, isd, b});
    endtask

    task automatic refresh(input int x0, input int y0, input int x1, input int y1,
                           input bit fx, input bit sw);
        logic [15:0] xe, ye, v;
        logic [PW-1:0] p;
        int n;
        xe = 16'(x1 - 1);
        ye = 16'(y1 - 1);
        push_exp(0, 0, 8'h2A);
        push_exp(1, 1, 8'(x0 >> 8)); push_exp(1, 1, 8'(x0));
        push_exp(1, 1, xe[15:8]);   push_exp(1, 1, xe[7:0]);
        push_exp(0, 0, 8'h2B);
        push_exp(1, 1, 8'(y0 >> 8)); push_exp(1, 1, 8'(y0));
        push_exp(1, 1, ye[15:8]);   push_exp(1, 1, ye[7:0]);
        push_exp(0, 0, 8'h2C);
        n = (x1 - x0) * (y1 - y0);
        for (int k = 0; k < n; k++) begin
            p = pixf(exp_base + k);
            v = fx ? {p[23:19], p[15:10], p[7:3]} : p[15:0];
            if (sw) begin push_exp(2, 1, v[7:0]);  push_exp(2, 1, v[15:8]); end
            else    begin push_exp(2, 1, v[15:8]); push_exp(2, 1, v[7:0]);  end
        end
        exp_base += n;
        @(negedge clk);
        req_x0 = 16'(x0); req_y0 = 16'(y0); req_x1 = 16'(x1); req_y1 = 16'(y1);
        fmt_xrgb = fx; swap_bytes = sw; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        fmt_xrgb = ~fx; swap_bytes = ~sw;
    endtask

    task automatic wait_done();
        bit seen = 1'b0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                chk(exp_q.size() == 0, "R3 byte count", exp_q.size(), 0);
                chk(cyc == last_hs, "R9 done timing", cyc, last_hs);
                chk(busy == 1'b0, "R9 busy low with done", busy, 0);
                @(negedge clk);
                chk(done == 1'b0, "R9 done single pulse", done, 0);
            end
        end
        if (!seen) chk(1'b0, "R9 done never seen", 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 0, "R11 out_valid reset", out_valid, 0);
        chk(pix_ready == 0, "R11 pix_ready reset", pix_ready, 0);
        chk(busy == 0, "R11 busy reset", busy, 0);
        chk(done == 0, "R11 done reset", done, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R6: native, high byte first, ready always
        refresh(3, 5, 7, 8, 1'b0, 1'b0);
        wait_done();

        // R5 R6 R10: XRGB with swap, end crosses a byte boundary, stalls
        rnd_ready = 1'b1;
        refresh(16'h0123, 16'h01FF, 16'h0126, 16'h0201, 1'b1, 1'b1);
        wait_done();

        // R5: single pixel, XRGB high byte first
        refresh(0, 0, 1, 1, 1'b1, 1'b0);
        wait_done();

        // R7: disabled request is dropped
        enable = 1'b0;
        @(negedge clk);
        req_x0 = 1; req_y0 = 1; req_x1 = 4; req_y1 = 4; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (busy || done || pix_ready) chk(1'b0, "R7 activity while disabled", {busy, done, pix_ready}, 0);
        end
        chk(busy == 0 && done == 0, "R7 idle after disabled request", {busy, done}, 0);
        enable = 1'b1;

        // R8: second request while busy is ignored
        refresh(10, 20, 14, 23, 1'b0, 1'b1);
        repeat (15) @(negedge clk);
        chk(busy == 1'b1, "R8 busy mid refresh", busy, 1);
        req_x0 = 50; req_y0 = 60; req_x1 = 52; req_y1 = 61; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        repeat (40) @(negedge clk);
        chk(busy == 0 && exp_q.size() == 0, "R8 no extra refresh", busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule